// File: doc/BRIEF.md
# Fused Read-Modify-Write Execute Unit

This block is the execute stage that an 8-bit accumulator processor uses for its compound memory instructions. Each compound instruction first changes a fetched memory byte (shift left, rotate left, shift right, rotate right, decrement or increment) and then merges the changed byte into the accumulator (OR, AND, XOR, add with carry, compare, or subtract with borrow). The changed byte is the value that goes back to memory, and it is also the operand of the accumulator step. The unit also executes two paired-register instructions: a load that fills both A and X from one memory byte, and a store of A AND X.

The surrounding core supplies the opcode, the memory byte it has already read, the A and X registers and the C, Z, N and V flags, and pulses `strobe`. On that clock edge the unit registers the new A, X, flags, the write-back byte and a one-cycle write enable. Addresses, bus cycles and decimal arithmetic belong to the core. All arithmetic here is binary. An opcode that the unit does not execute raises `illegal` and hands back A, X and the flags unchanged.

Top module: `fused_rmw_exec`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to 0 after that edge.
- R2: Results are registered on an edge where `strobe` is high, and `res_vld` is high for exactly the following cycle. `mem_we` can be high only in that cycle. With `strobe` low, A, X, flags and `mem_out` hold their values.
- R3: The legal opcodes have low nibble 7 (any high nibble in the groups below), or low nibble F with bit 4 clear. The groups are selected by bits 7:5. For any other opcode, `illegal` goes to 1, `mem_we` stays 0, and A, X, C, Z, N and V come back equal to their inputs. For a legal opcode, `illegal` is 0.
- R4: Bits 7:5 = 000: the byte is shifted left with 0 entering bit 0. C takes the old bit 7. A becomes A OR the shifted byte. Z and N follow the new A, and V is kept.
- R5: Bits 7:5 = 001: the byte is rotated left with C entering bit 0. C takes the old bit 7. A becomes A AND the rotated byte. Z and N follow the new A, and V is kept.
- R6: Bits 7:5 = 010: the byte is shifted right with 0 entering bit 7. C takes the old bit 0. A becomes A XOR the shifted byte. Z and N follow the new A, and V is kept.
- R7: Bits 7:5 = 011: the byte is rotated right with C entering bit 7. The old bit 0 is the carry-in of A + rotated byte. C, V, Z and N come from that binary addition.
- R8: Bits 7:5 = 110: the byte is decremented. A is unchanged. C = (A >= new byte) unsigned, Z = (A == new byte), N = bit 7 of A minus new byte, and V is kept.
- R9: Bits 7:5 = 111: the byte is incremented. A becomes A - new byte - (1 - C). C is the no-borrow carry, and V is signed overflow of that subtraction. Z and N follow the new A.
- R10: Opcodes 87, 97 and 8F write A AND X to memory. A, X, C, Z, N and V are unchanged.
- R11: Opcodes A7, AF and B7 load the memory byte into both A and X, and set Z and N from it. C and V are kept, and nothing is written.
- R12: The six modify groups write the modified byte (not the accumulator result) to memory, with `mem_we` high. X is unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe | input | 1 | Execute the presented opcode on this edge |
| opcode | input | 8 | Instruction byte |
| mem_in | input | 8 | Memory operand already fetched |
| acc_in | input | 8 | Current A |
| xr_in | input | 8 | Current X |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| n_in | input | 1 | Current negative flag |
| v_in | input | 1 | Current overflow flag |
| res_vld | output | 1 | Registered results are new this cycle |
| illegal | output | 1 | Last strobed opcode was not executable |
| mem_we | output | 1 | Write `mem_out` back to memory this cycle |
| mem_out | output | 8 | Byte to write back |
| acc_out | output | 8 | New A |
| xr_out | output | 8 | New X |
| c_out | output | 1 | New carry flag |
| z_out | output | 1 | New zero flag |
| n_out | output | 1 | New negative flag |
| v_out | output | 1 | New overflow flag |

## Verification
The hardest cases to reach are the carry chains that cross the two halves of one instruction. These include a rotate-right whose dropped bit 0 must feed the addition and create signed overflow, an increment of FF that wraps to 00 before a borrow subtraction, and a decrement of 00 that wraps to FF and then compares equal to A. Directed stimulus sets the memory byte, A and the incoming carry so that each of these chains is taken. A few hundred random operands, spread over every legal opcode and a set of illegal neighbours, then cover the remaining flag combinations.

// File: rtl/fused_exec_pkg.sv
// Shared types for the fused read-modify-write execute unit.
// Assumes: one operation class per opcode, flags carried as a packed group.
package fused_exec_pkg;

    // Operation class decoded from the opcode byte
    typedef enum logic [3:0] {
        K_NONE,
        K_SHL_OR,
        K_ROL_AND,
        K_SHR_XOR,
        K_ROR_ADD,
        K_DEC_CMP,
        K_INC_SUB,
        K_STORE_AX,
        K_LOAD_AX
    } op_kind_e;

    // Status flags touched by this unit
    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } flags_t;

endpackage

// File: rtl/fused_decode.sv
// Opcode decoder: maps an instruction byte to an operation class.
// Assumes: only low nibble 7 (either setting of bit 4) or low nibble F with
// bit 4 clear are executable; bits 7:5 choose the group.
module fused_decode
    import fused_exec_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic [OPW-1:0] opcode,
    output op_kind_e       kind,
    output logic           legal
);

    localparam logic [3:0] LO_DIRECT = 4'h7;
    localparam logic [3:0] LO_WIDE   = 4'hF;

    logic mode_ok;

    // Addressing form check on the low nibble and bit 4
    always_comb begin
        mode_ok = (opcode[3:0] == LO_DIRECT) ||
                  ((opcode[3:0] == LO_WIDE) && !opcode[4]);
    end

    // Group selection from the top three bits
    always_comb begin
        kind = K_NONE;
        if (mode_ok) begin
            case (opcode[OPW-1:OPW-3])
                3'd0:    kind = K_SHL_OR;
                3'd1:    kind = K_ROL_AND;
                3'd2:    kind = K_SHR_XOR;
                3'd3:    kind = K_ROR_ADD;
                3'd4:    kind = K_STORE_AX;
                3'd5:    kind = K_LOAD_AX;
                3'd6:    kind = K_DEC_CMP;
                default: kind = K_INC_SUB;
            endcase
        end
    end

    // A class other than K_NONE is executable
    always_comb begin
        legal = (kind != K_NONE);
    end

endmodule

// File: rtl/fused_modify.sv
// Memory-side modifier: shift, rotate, increment or decrement of the operand.
// Assumes: the incoming carry enters rotates; the bit pushed out is reported.
module fused_modify
    import fused_exec_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_kind_e      kind,
    input  logic [DW-1:0] mem_val,
    input  logic          c_in,
    output logic [DW-1:0] mod_val,
    output logic          out_bit
);

    localparam logic [DW-1:0] ONE = DW'(1);

    // Produce the modified operand and the bit that leaves it
    always_comb begin
        mod_val = mem_val;
        out_bit = c_in;
        case (kind)
            K_SHL_OR: begin
                mod_val = {mem_val[DW-2:0], 1'b0};
                out_bit = mem_val[DW-1];
            end
            K_ROL_AND: begin
                mod_val = {mem_val[DW-2:0], c_in};
                out_bit = mem_val[DW-1];
            end
            K_SHR_XOR: begin
                mod_val = {1'b0, mem_val[DW-1:1]};
                out_bit = mem_val[0];
            end
            K_ROR_ADD: begin
                mod_val = {c_in, mem_val[DW-1:1]};
                out_bit = mem_val[0];
            end
            K_DEC_CMP: mod_val = mem_val - ONE;
            K_INC_SUB: mod_val = mem_val + ONE;
            default: ;
        endcase
    end

endmodule

// File: rtl/fused_combine.sv
// Accumulator-side combiner: merges the modified byte into A and derives flags.
// Assumes: binary arithmetic only; one shared adder serves add, compare and
// subtract by choosing the second operand and the carry-in.
module fused_combine
    import fused_exec_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_kind_e      kind,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] xr_in,
    input  logic [DW-1:0] mem_val,
    input  logic [DW-1:0] mod_val,
    input  logic          out_bit,
    input  flags_t        f_in,
    output logic [DW-1:0] acc_nx,
    output logic [DW-1:0] xr_nx,
    output flags_t        f_nx,
    output logic [DW-1:0] wr_val,
    output logic          wr_en
);

    localparam int MSB = DW - 1;

    logic [DW-1:0] add_b;
    logic          add_ci;
    logic [DW:0]   add_sum;
    logic          add_ovf;
    logic [DW-1:0] logic_res;

    // Select the adder's second operand and carry-in per class
    always_comb begin
        add_b  = mod_val;
        add_ci = out_bit;
        case (kind)
            K_DEC_CMP: begin
                add_b  = ~mod_val;
                add_ci = 1'b1;
            end
            K_INC_SUB: begin
                add_b  = ~mod_val;
                add_ci = f_in.c;
            end
            default: ;
        endcase
    end

    // Shared binary adder with signed overflow detect
    always_comb begin
        add_sum = {1'b0, acc_in} + {1'b0, add_b} + {{DW{1'b0}}, add_ci};
        add_ovf = (acc_in[MSB] == add_b[MSB]) && (add_sum[MSB] != acc_in[MSB]);
    end

    // Bitwise merge for the three logic groups
    always_comb begin
        case (kind)
            K_SHL_OR:  logic_res = acc_in | mod_val;
            K_ROL_AND: logic_res = acc_in & mod_val;
            default:   logic_res = acc_in ^ mod_val;
        endcase
    end

    // Next A, X, flags and memory write per class
    always_comb begin
        acc_nx = acc_in;
        xr_nx  = xr_in;
        f_nx   = f_in;
        wr_val = mod_val;
        wr_en  = 1'b0;
        case (kind)
            K_SHL_OR, K_ROL_AND, K_SHR_XOR: begin
                acc_nx = logic_res;
                f_nx.c = out_bit;
                f_nx.z = (logic_res == '0);
                f_nx.n = logic_res[MSB];
                wr_en  = 1'b1;
            end
            K_ROR_ADD, K_INC_SUB: begin
                acc_nx = add_sum[DW-1:0];
                f_nx.c = add_sum[DW];
                f_nx.v = add_ovf;
                f_nx.z = (add_sum[DW-1:0] == '0);
                f_nx.n = add_sum[MSB];
                wr_en  = 1'b1;
            end
            K_DEC_CMP: begin
                f_nx.c = add_sum[DW];
                f_nx.z = (add_sum[DW-1:0] == '0);
                f_nx.n = add_sum[MSB];
                wr_en  = 1'b1;
            end
            K_STORE_AX: begin
                wr_val = acc_in & xr_in;
                wr_en  = 1'b1;
            end
            K_LOAD_AX: begin
                acc_nx = mem_val;
                xr_nx  = mem_val;
                f_nx.z = (mem_val == '0);
                f_nx.n = mem_val[MSB];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fused_rmw_exec.sv
// Top of the fused read-modify-write execute unit: decode, modify, combine,
// then register everything on strobe.
// Assumes: operands are stable during the strobe cycle; addressing and
// decimal adjustment are done elsewhere; reset is synchronous, active low.
module fused_rmw_exec
    import fused_exec_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe,
    input  logic [OPW-1:0] opcode,
    input  logic [DW-1:0]  mem_in,
    input  logic [DW-1:0]  acc_in,
    input  logic [DW-1:0]  xr_in,
    input  logic           c_in,
    input  logic           z_in,
    input  logic           n_in,
    input  logic           v_in,
    output logic           res_vld,
    output logic           illegal,
    output logic           mem_we,
    output logic [DW-1:0]  mem_out,
    output logic [DW-1:0]  acc_out,
    output logic [DW-1:0]  xr_out,
    output logic           c_out,
    output logic           z_out,
    output logic           n_out,
    output logic           v_out
);

    op_kind_e      kind;
    logic          legal;
    logic [DW-1:0] mod_val;
    logic          out_bit;
    logic [DW-1:0] acc_nx;
    logic [DW-1:0] xr_nx;
    logic [DW-1:0] wr_val;
    logic          wr_en;
    flags_t        f_in;
    flags_t        f_nx;
    flags_t        f_q;

    // Gather incoming flags into one group
    always_comb begin
        f_in = '{c: c_in, z: z_in, n: n_in, v: v_in};
    end

    fused_decode #(.OPW(OPW)) i_decode (
        .opcode (opcode),
        .kind   (kind),
        .legal  (legal)
    );

    fused_modify #(.DW(DW)) i_modify (
        .kind    (kind),
        .mem_val (mem_in),
        .c_in    (c_in),
        .mod_val (mod_val),
        .out_bit (out_bit)
    );

    fused_combine #(.DW(DW)) i_combine (
        .kind    (kind),
        .acc_in  (acc_in),
        .xr_in   (xr_in),
        .mem_val (mem_in),
        .mod_val (mod_val),
        .out_bit (out_bit),
        .f_in    (f_in),
        .acc_nx  (acc_nx),
        .xr_nx   (xr_nx),
        .f_nx    (f_nx),
        .wr_val  (wr_val),
        .wr_en   (wr_en)
    );

    // Result registers: capture on strobe, hold otherwise, pulse valid/write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld <= 1'b0;
            illegal <= 1'b0;
            mem_we  <= 1'b0;
            mem_out <= '0;
            acc_out <= '0;
            xr_out  <= '0;
            f_q     <= '0;
        end else begin
            res_vld <= strobe;
            mem_we  <= strobe && legal && wr_en;
            if (strobe) begin
                illegal <= !legal;
                mem_out <= wr_val;
                acc_out <= acc_nx;
                xr_out  <= xr_nx;
                f_q     <= f_nx;
            end
        end
    end

    // Drive flag outputs from the registered group
    always_comb begin
        c_out = f_q.c;
        z_out = f_q.z;
        n_out = f_q.n;
        v_out = f_q.v;
    end

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> res_vld) else $error("valid missing"); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (!res_vld && !mem_we && $stable(acc_out) && $stable(xr_out)))
        else $error("idle change"); // R2
    AST_WRITE_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> res_vld) else $error("stray write"); // R12
    AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && kind == K_NONE) |=> (illegal && !mem_we &&
            acc_out == $past(acc_in) && xr_out == $past(xr_in) &&
            c_out == $past(c_in) && v_out == $past(v_in)))
        else $error("illegal changed state"); // R3
    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && kind == K_DEC_CMP) |=> (acc_out == $past(acc_in) && mem_we))
        else $error("compare altered A"); // R8
    AST_STORE_PURE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && kind == K_STORE_AX) |=> (mem_we &&
            mem_out == ($past(acc_in) & $past(xr_in)) &&
            z_out == $past(z_in) && n_out == $past(n_in)))
        else $error("store side effect"); // R10
    AST_LOAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && kind == K_LOAD_AX) |=> (acc_out == xr_out && !mem_we))
        else $error("load pair mismatch"); // R11

endmodule

// File: tb/test_fused_rmw_exec.sv
// Scoreboard bench: the driver computes expected results from the
// requirements and queues them; the monitor compares when res_vld is seen.
module test_fused_rmw_exec;

    typedef struct {
        string      tag;
        logic [7:0] op;
        logic [7:0] mem;
        logic [7:0] acc;
        logic [7:0] xr;
        logic       c, z, n, v, ill, we;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic [7:0] opcode = '0, mem_in = '0, acc_in = '0, xr_in = '0;
    logic       c_in = 1'b0, z_in = 1'b0, n_in = 1'b0, v_in = 1'b0;
    logic       res_vld, illegal, mem_we, c_out, z_out, n_out, v_out;
    logic [7:0] mem_out, acc_out, xr_out;

    int   total = 0;
    int   bad   = 0;
    int   cycles = 0;
    exp_t sb[$];
    exp_t last;

    always #10 clk = ~clk;

    fused_rmw_exec i_fused_rmw_exec (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .opcode(opcode),
        .mem_in(mem_in), .acc_in(acc_in), .xr_in(xr_in),
        .c_in(c_in), .z_in(z_in), .n_in(n_in), .v_in(v_in),
        .res_vld(res_vld), .illegal(illegal), .mem_we(mem_we),
        .mem_out(mem_out), .acc_out(acc_out), .xr_out(xr_out),
        .c_out(c_out), .z_out(z_out), .n_out(n_out), .v_out(v_out)
    );

    // Expected behaviour built from the requirement text
    function automatic exp_t model(input logic [7:0] op, m, a, x,
                                   input logic c, z, n, v);
        exp_t e;
        logic [7:0] r;
        logic [8:0] t;
        logic form_ok;
        e.op = op; e.acc = a; e.xr = x; e.mem = 8'h00;
        e.c = c; e.z = z; e.n = n; e.v = v; e.ill = 1'b0; e.we = 1'b0;
        form_ok = (op[3:0] == 4'h7) || (op[3:0] == 4'hF && op[4] == 1'b0);
        if (!form_ok) begin
            e.tag = "R3"; e.ill = 1'b1; return e;
        end
        case (op[7:5])
            3'b000: begin
                e.tag = "R4"; r = {m[6:0], 1'b0}; e.c = m[7]; e.acc = a | r;
                e.z = (e.acc == 0); e.n = e.acc[7]; e.mem = r; e.we = 1'b1;
            end
            3'b001: begin
                e.tag = "R5"; r = {m[6:0], c}; e.c = m[7]; e.acc = a & r;
                e.z = (e.acc == 0); e.n = e.acc[7]; e.mem = r; e.we = 1'b1;
            end
            3'b010: begin
                e.tag = "R6"; r = {1'b0, m[7:1]}; e.c = m[0]; e.acc = a ^ r;
                e.z = (e.acc == 0); e.n = e.acc[7]; e.mem = r; e.we = 1'b1;
            end
            3'b011: begin
                e.tag = "R7"; r = {c, m[7:1]};
                t = {1'b0, a} + {1'b0, r} + {8'h00, m[0]};
                e.acc = t[7:0]; e.c = t[8];
                e.v = (a[7] == r[7]) && (t[7] != a[7]);
                e.z = (e.acc == 0); e.n = e.acc[7]; e.mem = r; e.we = 1'b1;
            end
            3'b110: begin
                e.tag = "R8"; r = m - 8'd1;
                e.c = (a >= r); e.z = (a == r); t[7:0] = a - r; e.n = t[7];
                e.mem = r; e.we = 1'b1;
            end
            3'b111: begin
                e.tag = "R9"; r = m + 8'd1;
                t = {1'b0, a} - {1'b0, r} - {8'h00, ~c};
                e.acc = t[7:0]; e.c = ~t[8];
                e.v = (a[7] != r[7]) && (t[7] != a[7]);
                e.z = (e.acc == 0); e.n = e.acc[7]; e.mem = r; e.we = 1'b1;
            end
            3'b100: begin
                e.tag = "R10"; e.mem = a & x; e.we = 1'b1;
            end
            default: begin
                e.tag = "R11"; e.acc = m; e.xr = m;
                e.z = (m == 0); e.n = m[7];
            end
        endcase
        return e;
    endfunction

    // Driver: present one operation for one cycle and queue its expectation
    task automatic issue(input logic [7:0] op, m, a, x, input logic c, z, n, v);
        @(negedge clk);
        opcode = op; mem_in = m; acc_in = a; xr_in = x;
        c_in = c; z_in = z; n_in = n; v_in = v; strobe = 1'b1;
        sb.push_back(model(op, m, a, x, c, z, n, v));
        @(negedge clk);
        strobe = 1'b0;
        opcode = 8'h02; mem_in = ~m; acc_in = ~a; xr_in = ~x;
    endtask

    // Monitor: compare every produced result against the queue head
    always @(negedge clk) begin
        if (rst_n && res_vld) begin
            exp_t e;
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected result: res_vld=1 expected 0");
            end else begin
                e = sb.pop_front();
                last = e;
                if (illegal !== e.ill || mem_we !== e.we || acc_out !== e.acc ||
                    xr_out !== e.xr || c_out !== e.c || z_out !== e.z ||
                    n_out !== e.n || v_out !== e.v ||
                    (e.we && mem_out !== e.mem)) begin
                    bad++;
                    $display("FAIL %s op=%h: got ill=%b we=%b mem=%h a=%h x=%h czn v=%b%b%b%b exp ill=%b we=%b mem=%h a=%h x=%h czn v=%b%b%b%b",
                        e.tag, e.op, illegal, mem_we, mem_out, acc_out, xr_out,
                        c_out, z_out, n_out, v_out, e.ill, e.we, e.mem, e.acc,
                        e.xr, e.c, e.z, e.n, e.v);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check_bit(input string tag, input logic got, input logic want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, got, want);
        end
    endtask

    initial begin
        logic [7:0] ops [16];
        ops = '{8'h07, 8'h0F, 8'h17, 8'h27, 8'h2F, 8'h57, 8'h6F, 8'h77,
                8'hC7, 8'hCF, 8'hE7, 8'hF7, 8'h87, 8'h97, 8'hA7, 8'hB7};
        repeat (3) @(negedge clk);
        // R1: reset values
        total++;
        if ({res_vld, illegal, mem_we, mem_out, acc_out, xr_out,
             c_out, z_out, n_out, v_out} !== '0) begin
            bad++;
            $display("FAIL R1 reset outputs: got a=%h x=%h mem=%h expected 00",
                     acc_out, xr_out, mem_out);
        end
        @(negedge clk); rst_n = 1'b1;

        // R4: shift-left then OR, carry from bit 7, zero result
        issue(8'h07, 8'h80, 8'h00, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
        // R5: rotate-left with carry in then AND
        issue(8'h2F, 8'h81, 8'hFF, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0);
        // R6: shift-right then XOR, carry from bit 0
        issue(8'h57, 8'h03, 8'h81, 8'h33, 1'b0, 1'b1, 1'b0, 1'b0);
        // R7: rotate-right, dropped bit feeds the add and overflows
        issue(8'h6F, 8'h81, 8'h7F, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0);
        issue(8'h77, 8'hFF, 8'h80, 8'h44, 1'b1, 1'b0, 1'b0, 1'b0);
        // R8: decrement of 00 wraps to FF and compares equal
        issue(8'hC7, 8'h00, 8'hFF, 8'h55, 1'b0, 1'b0, 1'b1, 1'b1);
        issue(8'hCF, 8'h10, 8'h05, 8'h55, 1'b1, 1'b1, 1'b0, 1'b0);
        // R9: increment of FF wraps to 00, then borrow subtract
        issue(8'hE7, 8'hFF, 8'h00, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0);
        issue(8'hF7, 8'h7F, 8'h7F, 8'h66, 1'b1, 1'b0, 1'b0, 1'b0);
        // R10: store A AND X, flags untouched
        issue(8'h97, 8'h00, 8'hF0, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b1);
        // R11: paired load, zero and negative cases
        issue(8'hAF, 8'h00, 8'h12, 8'h34, 1'b1, 1'b0, 1'b1, 1'b1);
        issue(8'hB7, 8'h80, 8'h12, 8'h34, 1'b0, 1'b1, 1'b0, 1'b0);
        // R3: illegal neighbours leave state alone
        issue(8'h1F, 8'h55, 8'hAA, 8'h0F, 1'b1, 1'b1, 1'b0, 1'b1);
        issue(8'h9F, 8'h55, 8'hAA, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b0);
        issue(8'h03, 8'h55, 8'hAA, 8'h0F, 1'b1, 1'b0, 1'b1, 1'b0);
        issue(8'hA9, 8'h55, 8'hAA, 8'h0F, 1'b0, 1'b1, 1'b1, 1'b1);

        // R2: outputs hold and nothing pulses while idle
        repeat (3) @(negedge clk);
        check_bit("R2 idle valid", res_vld, 1'b0);
        check_bit("R2 idle write", mem_we, 1'b0);
        check_bit("R2 idle hold A", acc_out == last.acc, 1'b1);

        // R12 and all groups: random operands over legal and illegal codes
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            logic [3:0] fl;
            op = (i % 5 == 4) ? 8'($urandom) : ops[i % 16];
            fl = 4'($urandom);
            issue(op, 8'($urandom), 8'($urandom), 8'($urandom),
                  fl[0], fl[1], fl[2], fl[3]);
        end
        repeat (4) @(negedge clk);
        check_bit("R2 queue drained", sb.size() == 0, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule